// File: doc/BRIEF.md
# Interlocked Read Handshake Between Two Clock Domains

This block carries one read from a requester to a responder over a bus that has no shared clock. Three control wires pace the exchange: a read request, an acknowledge, and a data-ready strobe. One set of shared data lines first carries the address from the requester and later carries the read data back. Every edge on a control wire is caused by the opposite edge that the other side produced before it. Neither side needs to know how fast the other runs.

Each side runs on its own clock and sees the other side's control wires only through two-flop synchronizers. It acts on synchronized levels and never on raw edges. The requester takes a start pulse and an address. When the exchange is complete, it returns the fetched word together with a one-cycle done pulse. The responder serves reads from a small register array. That array is filled through a write port in the responder's clock domain.

Drive direction on the shared lines is modelled as two separate output enables. The block exposes the bus wires so that the exchange can be observed.

Top module: `hsk_read_bus`

## Requirements
- R1: After the synchronous active-high resets, both sides are idle. Request, acknowledge, data-ready, both drive enables, `busy` and `done` are all low.
- R2: When `start` is sampled high in idle, the requester raises request and its drive enable in the same cycle. It places the address on the data lines, zero-extended into the low bits. `busy` rises at the same time.
- R3: The responder captures the address and raises acknowledge when it sees request high. The requester drops request and its drive enable only after it sees acknowledge, so acknowledge is still high when request falls.
- R4: The responder drops acknowledge once it sees request low. Only after it sees acknowledge low does it raise data-ready and drive the addressed array word. At that point request and acknowledge are both low.
- R5: The requester latches the data lines when it sees data-ready, then raises acknowledge. The responder drops data-ready and its drive enable only after it sees that acknowledge.
- R6: The requester drops acknowledge once it sees data-ready low. After it sees acknowledge low, it gives a single-cycle `done` with `data_out` equal to the array word at the requested address. At that cycle acknowledge and data-ready are low.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It causes no second request and no second `done`.
- R8: The two drive enables on the shared data lines are never high together.
- R9: Request and data-ready are never high together, and the two sides never drive acknowledge at the same time.
- R10: A write on the load port (`ld_en` high on a responder clock edge) sets array entry `ld_addr` to `ld_data`, and later reads return the new value.
- R11: `busy` stays high from the cycle after an accepted `start` until the cycle in which `done` is high, and is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req | input | 1 | Requester clock |
| rst_req | input | 1 | Requester synchronous reset, active high |
| start | input | 1 | Begin a read with `addr_in` |
| addr_in | input | AW | Array address to read |
| busy | output | 1 | Requester is in a transaction |
| done | output | 1 | One-cycle completion pulse |
| data_out | output | BW | Word returned by the last read |
| clk_rsp | input | 1 | Responder clock |
| rst_rsp | input | 1 | Responder synchronous reset, active high |
| ld_en | input | 1 | Array write strobe |
| ld_addr | input | AW | Array write address |
| ld_data | input | BW | Array write data |
| bus_rreq | output | 1 | Read request wire |
| bus_ack | output | 1 | Acknowledge wire (either side) |
| bus_drdy | output | 1 | Data-ready wire |
| bus_data | output | BW | Shared address/data lines |
| req_drive | output | 1 | Requester drives the data lines |
| rsp_drive | output | 1 | Responder drives the data lines |

## Verification
A side that leaves its state too early breaks the interlock at the bus wires within a few cycles of its own clock. For example, request may fall while acknowledge is low, data-ready may rise with acknowledge still high, or both drive enables may overlap. The bench records the order of these edges at every requester clock. A wrong captured address or a stale array read instead shows up only at `done`, as a wrong `data_out` or wrong data on the lines while data-ready is high. A requester that accepts `start` while busy shows a second request rising within a cycle of completion.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_WDATA, RQ_ACK, RQ_RELS
  } req_st_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ACK, RS_GAP, RS_DRIVE, RS_TAIL
  } rsp_st_t;
endpackage

// File: rtl/hsk_sync2.sv
module hsk_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hsk_requester.sv
module hsk_requester
  import hsk_pkg::*;
#(
  parameter int AW = 4,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          ack_in,
  input  logic          drdy_in,
  input  logic [BW-1:0] bus_in,
  output logic          rreq_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [BW-1:0] bus_o,
  output logic          done_o,
  output logic [BW-1:0] data_o,
  output logic          busy_o
);
  req_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RQ_IDLE;
      rreq_o <= 1'b0;
      ack_o  <= 1'b0;
      oe_o   <= 1'b0;
      bus_o  <= '0;
      done_o <= 1'b0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        RQ_IDLE: if (start) begin
          bus_o  <= BW'(addr);
          oe_o   <= 1'b1;
          rreq_o <= 1'b1;
          st     <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_in) begin
          rreq_o <= 1'b0;
          oe_o   <= 1'b0;
          st     <= RQ_WDATA;
        end
        RQ_WDATA: if (drdy_in) begin
          data_o <= bus_in;
          ack_o  <= 1'b1;
          st     <= RQ_ACK;
        end
        RQ_ACK: if (!drdy_in) begin
          ack_o <= 1'b0;
          st    <= RQ_RELS;
        end
        RQ_RELS: if (!ack_in) begin
          done_o <= 1'b1;
          st     <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end

  assign busy_o = (st != RQ_IDLE);
endmodule

// File: rtl/hsk_responder.sv
module hsk_responder
  import hsk_pkg::*;
#(
  parameter int AW = 4,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rreq_in,
  input  logic          ack_in,
  input  logic [BW-1:0] bus_in,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_data,
  output logic          ack_o,
  output logic          drdy_o,
  output logic          oe_o,
  output logic [BW-1:0] bus_o
);
  localparam int DEPTH = 1 << AW;

  rsp_st_t       st;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] rd_q;
  logic [BW-1:0] mem [DEPTH];

  // array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    rd_q <= mem[addr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RS_IDLE;
      addr_q <= '0;
      ack_o  <= 1'b0;
      drdy_o <= 1'b0;
      oe_o   <= 1'b0;
      bus_o  <= '0;
    end else begin
      unique case (st)
        RS_IDLE: if (rreq_in) begin
          addr_q <= bus_in[AW-1:0];
          ack_o  <= 1'b1;
          st     <= RS_ACK;
        end
        RS_ACK: if (!rreq_in) begin
          ack_o <= 1'b0;
          st    <= RS_GAP;
        end
        RS_GAP: if (!ack_in) begin
          bus_o  <= rd_q;
          oe_o   <= 1'b1;
          drdy_o <= 1'b1;
          st     <= RS_DRIVE;
        end
        RS_DRIVE: if (ack_in) begin
          drdy_o <= 1'b0;
          oe_o   <= 1'b0;
          st     <= RS_TAIL;
        end
        RS_TAIL: if (!ack_in) st <= RS_IDLE;
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsk_read_bus.sv
module hsk_read_bus #(
  parameter int AW = 4,
  parameter int BW = 16
) (
  input  logic          clk_req,
  input  logic          rst_req,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  output logic          busy,
  output logic          done,
  output logic [BW-1:0] data_out,
  input  logic          clk_rsp,
  input  logic          rst_rsp,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [BW-1:0] ld_data,
  output logic          bus_rreq,
  output logic          bus_ack,
  output logic          bus_drdy,
  output logic [BW-1:0] bus_data,
  output logic          req_drive,
  output logic          rsp_drive
);
  logic          req_rreq, req_ack, req_oe;
  logic [BW-1:0] req_bus;
  logic          rsp_ack, rsp_drdy, rsp_oe;
  logic [BW-1:0] rsp_bus;
  logic          ack_w;
  logic [BW-1:0] data_w;
  logic [1:0]    rq_sync, rs_sync;

  assign ack_w  = req_ack | rsp_ack;
  assign data_w = req_oe ? req_bus : (rsp_oe ? rsp_bus : '0);

  hsk_sync2 #(.W(2)) u_sync_req (
    .clk(clk_req), .rst(rst_req), .d({ack_w, rsp_drdy}), .q(rq_sync)
  );
  hsk_sync2 #(.W(2)) u_sync_rsp (
    .clk(clk_rsp), .rst(rst_rsp), .d({req_rreq, ack_w}), .q(rs_sync)
  );

  hsk_requester #(.AW(AW), .BW(BW)) u_req (
    .clk(clk_req), .rst(rst_req), .start(start), .addr(addr_in),
    .ack_in(rq_sync[1]), .drdy_in(rq_sync[0]), .bus_in(data_w),
    .rreq_o(req_rreq), .ack_o(req_ack), .oe_o(req_oe), .bus_o(req_bus),
    .done_o(done), .data_o(data_out), .busy_o(busy)
  );

  hsk_responder #(.AW(AW), .BW(BW)) u_rsp (
    .clk(clk_rsp), .rst(rst_rsp), .rreq_in(rs_sync[1]), .ack_in(rs_sync[0]),
    .bus_in(data_w), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .ack_o(rsp_ack), .drdy_o(rsp_drdy), .oe_o(rsp_oe), .bus_o(rsp_bus)
  );

  assign bus_rreq  = req_rreq;
  assign bus_ack   = ack_w;
  assign bus_drdy  = rsp_drdy;
  assign bus_data  = data_w;
  assign req_drive = req_oe;
  assign rsp_drive = rsp_oe;
endmodule

// File: rtl/hsk_read_bus_chk.sv
module hsk_read_bus_chk (
  input logic clk_req,
  input logic rst_req,
  input logic clk_rsp,
  input logic rst_rsp,
  input logic req_oe,
  input logic rsp_oe,
  input logic rreq,
  input logic drdy,
  input logic req_ack,
  input logic rsp_ack,
  input logic done,
  input logic busy
);
  assert_one_driver_R8: assert property (@(posedge clk_req) disable iff (rst_req)
    !(req_oe && rsp_oe));
  assert_one_driver_rsp_R8: assert property (@(posedge clk_rsp) disable iff (rst_rsp)
    !(req_oe && rsp_oe));
  assert_req_drdy_apart_R9: assert property (@(posedge clk_req) disable iff (rst_req)
    !(rreq && drdy));
  assert_single_ack_R9: assert property (@(posedge clk_rsp) disable iff (rst_rsp)
    !(req_ack && rsp_ack));
  assert_addr_with_req_R2: assert property (@(posedge clk_req) disable iff (rst_req)
    rreq |-> req_oe);
  assert_data_with_drdy_R4: assert property (@(posedge clk_rsp) disable iff (rst_rsp)
    drdy |-> rsp_oe);
  assert_done_pulse_R6: assert property (@(posedge clk_req) disable iff (rst_req)
    done |=> !done);
  assert_req_from_idle_R7: assert property (@(posedge clk_req) disable iff (rst_req)
    $rose(rreq) |-> !$past(busy));
endmodule

bind hsk_read_bus hsk_read_bus_chk u_chk (
  .clk_req(clk_req), .rst_req(rst_req), .clk_rsp(clk_rsp), .rst_rsp(rst_rsp),
  .req_oe(req_oe), .rsp_oe(rsp_oe), .rreq(req_rreq), .drdy(rsp_drdy),
  .req_ack(req_ack), .rsp_ack(rsp_ack), .done(done), .busy(busy)
);

// File: tb/hsk_read_bus_bench.sv
`timescale 1ns/1ps
module hsk_read_bus_bench;
  localparam int AW = 4;
  localparam int BW = 16;

  logic clk_req = 1'b0, clk_rsp = 1'b0;
  logic rst_req = 1'b1, rst_rsp = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [BW-1:0] ld_data = '0;
  logic busy, done, bus_rreq, bus_ack, bus_drdy, req_drive, rsp_drive;
  logic [BW-1:0] data_out, bus_data;

  logic [BW-1:0] model [1 << AW];
  int checks = 0, fails = 0, overlap = 0;
  bit finished = 0;

  always #10 clk_req = ~clk_req;   // 50 MHz
  always #13.5 clk_rsp = ~clk_rsp;

  hsk_read_bus #(.AW(AW), .BW(BW)) u_hsk_read_bus (
    .clk_req(clk_req), .rst_req(rst_req), .start(start), .addr_in(addr_in),
    .busy(busy), .done(done), .data_out(data_out),
    .clk_rsp(clk_rsp), .rst_rsp(rst_rsp), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .bus_rreq(bus_rreq), .bus_ack(bus_ack), .bus_drdy(bus_drdy),
    .bus_data(bus_data), .req_drive(req_drive), .rsp_drive(rsp_drive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R8 / R9 monitor on both clocks
  always @(negedge clk_req) if (!rst_req && ((req_drive && rsp_drive) || (bus_rreq && bus_drdy))) overlap++;
  always @(negedge clk_rsp) if (!rst_rsp && ((req_drive && rsp_drive) || (bus_rreq && bus_drdy))) overlap++;

  task automatic load(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk_rsp);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk_rsp);
    ld_en = 1'b0;
    model[a] = d;
  endtask

  task automatic run_read(input logic [AW-1:0] a, input bit inject, input logic [AW-1:0] a2);
    logic [BW-1:0] exp;
    bit p_rreq, p_drdy, got, saw_data, busy_bad;
    int cyc;
    exp = model[a];
    @(negedge clk_req);
    start = 1'b1; addr_in = a;
    @(negedge clk_req);
    start = 1'b0;
    check(bus_rreq && req_drive && !rsp_drive && busy, "R2", "request/drive/busy", {bus_rreq, req_drive, busy}, 3'b111);
    check(bus_data == BW'(a), "R2", "address on lines", bus_data, BW'(a));
    p_rreq = 1'b1; p_drdy = 1'b0; got = 0; saw_data = 0; busy_bad = 0; cyc = 0;
    while (!got && cyc < 400) begin
      @(negedge clk_req);
      cyc++;
      start = (inject && cyc == 3);
      if (inject && cyc == 3) addr_in = a2;
      if (p_rreq && !bus_rreq)
        check(bus_ack && !req_drive, "R3", "ack high when request falls", {bus_ack, req_drive}, 2'b10);
      if (!p_drdy && bus_drdy) begin
        saw_data = 1;
        check(!bus_ack && !bus_rreq && rsp_drive && !req_drive, "R4", "lines at data-ready rise",
              {bus_ack, bus_rreq, rsp_drive, req_drive}, 4'b0010);
        check(bus_data == exp, "R4", "data on lines", bus_data, exp);
      end
      if (p_drdy && !bus_drdy)
        check(bus_ack && !rsp_drive, "R5", "ack high when data-ready falls", {bus_ack, rsp_drive}, 2'b10);
      if (done) begin
        got = 1;
        check(data_out == exp, "R6", "data_out at done", data_out, exp);
        check(!bus_ack && !bus_drdy && !busy, "R6", "quiet bus at done", {bus_ack, bus_drdy, busy}, 3'b000);
      end else if (!busy) busy_bad = 1;
      p_rreq = bus_rreq; p_drdy = bus_drdy;
    end
    start = 1'b0;
    check(got, "R6", "done seen", got, 1);
    check(saw_data, "R4", "data phase seen", saw_data, 1);
    check(!busy_bad, "R11", "busy held until done", busy_bad, 0);
    @(negedge clk_req);
    check(!done, "R6", "done one cycle", done, 0);
    if (inject) begin
      bit extra;
      extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_req);
        if (bus_rreq || done || busy) extra = 1;
      end
      check(!extra, "R7", "start while busy ignored", extra, 0);
    end
  endtask

  initial begin
    #(20.0 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_rsp);
    rst_req = 1'b0; rst_rsp = 1'b0;
    @(negedge clk_req);
    // R1: idle after reset
    check(!busy && !done && !bus_rreq && !bus_ack && !bus_drdy && !req_drive && !rsp_drive,
          "R1", "reset state", {busy, done, bus_rreq, bus_ack, bus_drdy, req_drive, rsp_drive}, 0);
    // R10: fill array
    for (int i = 0; i < (1 << AW); i++) load(AW'(i), BW'(i * 16'h1111) ^ 16'h5A3C);
    load(AW'(15), 16'hFFFF);
    run_read(4'd0, 0, 4'd0);
    run_read(4'd15, 0, 4'd0);
    run_read(4'd7, 0, 4'd0);
    run_read(4'd8, 0, 4'd0);   // back to back
    run_read(4'd3, 1, 4'd9);   // R7
    load(4'd5, 16'h0000);      // R10 overwrite
    run_read(4'd5, 0, 4'd0);
    load(4'd5, 16'hA5C3);
    run_read(4'd5, 0, 4'd0);
    check(overlap == 0, "R8", "drivers or request/data-ready overlap (R9)", overlap, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule